// File: doc/BRIEF.md
# Auto-Restart Protection Sequencer

This block is the fault and supply-lockout controller of an off-line switching regulator. It reads comparator flags from the analog front end: supply above the start level, supply below the stop level, control voltage above the overload level, supply over-voltage, feedback below the open-loop level, die over-temperature and temperature recovered. It also reads a flag that is high while soft-start is running. From these it drives three outputs: the power-switch enable, the enable of the high-voltage supply regulator, and a one-cycle request that launches a new soft-start.

Any fault stops switching. The supply is then held in regulation for a fixed restart interval. After that the regulator is released and the supply decays. The fault is forgotten only when the supply has fallen through the stop level, and charging then starts again. An overload must persist for a qualification window before it counts. An over-temperature fault also holds the block until the recovery flag is seen. Both intervals are parameters in clock cycles.

Top module: `autorestart_seq`

## Requirements
- R1: While reset is asserted all three outputs are low. In the first cycle after reset is released, hvreg_en is 1 and sw_en is 0 (charging).
- R2: While charging, a high vcc_above_start sets sw_en to 1 from the next cycle. ss_req is 1 in exactly that first switching cycle and 0 after it.
- R3: While switching, a high vcc_below_stop clears sw_en in the next cycle and returns to charging with hvreg_en at 1. This check takes priority over every fault.
- R4: An overload is declared only after comp_over_ovl has been sampled high on OVL_CYCLES consecutive clock edges while switching. sw_en is 0 after the OVL_CYCLES-th such edge. A shorter run, followed by a low sample, restarts the count.
- R5: While switching, a high vcc_over_ovp clears sw_en in the next cycle.
- R6: While switching, a high fb_below_open clears sw_en in the next cycle only if ss_active is 0. While ss_active is 1 it has no effect.
- R7: After a fault, sw_en stays 0 and hvreg_en stays 1 for exactly HOLD_CYCLES cycles. hvreg_en is then 0.
- R8: With the regulator released after a hold, vcc_above_start is ignored (sw_en and hvreg_en stay 0). A high vcc_below_stop returns the block to charging (hvreg_en 1) in the next cycle.
- R9: A temp_hot sample stops switching and sets a thermal latch, which is cleared by temp_cool. The hold does not end while the latch is set, even after HOLD_CYCLES. It ends on the second edge after temp_cool is first sampled high.
- R10: sw_en is never 1 while hvreg_en is 0, and ss_req is never 1 while sw_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timers count it |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_above_start | input | 1 | Supply has risen above the start level |
| vcc_below_stop | input | 1 | Supply has fallen below the stop level |
| comp_over_ovl | input | 1 | Control voltage above the overload level |
| vcc_over_ovp | input | 1 | Supply above the over-voltage level |
| fb_below_open | input | 1 | Feedback below the open-loop level |
| temp_hot | input | 1 | Die temperature above the shutdown level |
| temp_cool | input | 1 | Die temperature back below the recovery level |
| ss_active | input | 1 | Soft-start is in progress |
| sw_en | output | 1 | Power-switch enable |
| hvreg_en | output | 1 | High-voltage supply regulator enable |
| ss_req | output | 1 | One-cycle soft-start launch request |

## Verification
The bench builds the block with OVL_CYCLES = 8 and HOLD_CYCLES = 20. These values replace the tens of millions of cycles of a real build, so every overload run length from 1 to the full window can be swept, and each restart hold can be counted edge by edge. The short hold also lets the bench walk the thermal case past hold expiry and into the two-edge release after recovery. It also reaches every path through discharge and back to charging within one short run.

// File: rtl/arseq_pkg.sv
package arseq_pkg;

   typedef enum logic [2:0] {
      ST_OFF    = 3'd0,
      ST_CHARGE = 3'd1,
      ST_RUN    = 3'd2,
      ST_HOLD   = 3'd3,
      ST_DRAIN  = 3'd4
   } arseq_state_t;

endpackage

// File: rtl/arseq_timer.sv
// Qualification / interval counter: counts edges while run is high,
// clears when run drops, saturates at the last count.
module arseq_timer #(
   parameter int unsigned LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int unsigned CW = (LEN > 2) ? $clog2(LEN) : 1;
   localparam logic [CW-1:0] LAST = CW'(LEN - 1);

   generate
      if (LEN < 2) begin : g_bad_len
         $error("arseq_timer: LEN must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run)
         cnt <= '0;
      else if (cnt != LAST)
         cnt <= cnt + 1'b1;
   end

   assign expired = run && (cnt == LAST);

   // R4: a count is only reachable through an unbroken run of high samples
   p_count_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> $past(run));

endmodule

// File: rtl/arseq_fault_eval.sv
// Combines the instantaneous fault flags, qualifies overload over a window
// and keeps the thermal latch.
module arseq_fault_eval #(
   parameter int unsigned OVL_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic running,
   input  logic comp_over_ovl,
   input  logic vcc_over_ovp,
   input  logic fb_below_open,
   input  logic ss_active,
   input  logic temp_hot,
   input  logic temp_cool,
   output logic fault_now,
   output logic therm_hold
);
   logic ovl_expired;
   logic open_loop;

   arseq_timer #(.LEN(OVL_CYCLES)) u_ovl_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (running && comp_over_ovl),
      .expired (ovl_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         therm_hold <= 1'b0;
      else if (temp_hot)
         therm_hold <= 1'b1;
      else if (temp_cool)
         therm_hold <= 1'b0;
   end

   assign open_loop = fb_below_open && !ss_active;
   assign fault_now = running &&
                      (ovl_expired || vcc_over_ovp || open_loop || temp_hot);

   // R9: the latch survives until a recovery sample is seen
   p_therm_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (therm_hold && !temp_cool) |=> therm_hold);

   // R6: soft-start masks the open-loop condition
   p_fb_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_active && !comp_over_ovl && !vcc_over_ovp && !temp_hot) |-> !fault_now);

endmodule

// File: rtl/arseq_fsm.sv
module arseq_fsm
   import arseq_pkg::*;
#(
   parameter int unsigned HOLD_CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic above_start,
   input  logic below_stop,
   input  logic fault_now,
   input  logic therm_hold,
   output logic running,
   output logic sw_en,
   output logic hvreg_en,
   output logic ss_req
);
   arseq_state_t state, state_nx;
   logic hold_done;

   arseq_timer #(.LEN(HOLD_CYCLES)) u_hold_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state == ST_HOLD),
      .expired (hold_done)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_OFF:    state_nx = ST_CHARGE;
         ST_CHARGE: if (above_start) state_nx = ST_RUN;
         ST_RUN: begin
            if (below_stop)     state_nx = ST_CHARGE;
            else if (fault_now) state_nx = ST_HOLD;
         end
         ST_HOLD:   if (hold_done && !therm_hold) state_nx = ST_DRAIN;
         ST_DRAIN:  if (below_stop) state_nx = ST_CHARGE;
         default:   state_nx = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_OFF;
         ss_req <= 1'b0;
      end else begin
         state  <= state_nx;
         ss_req <= (state == ST_CHARGE) && above_start;
      end
   end

   assign running  = (state == ST_RUN);
   assign sw_en    = running;
   assign hvreg_en = (state == ST_CHARGE) || (state == ST_RUN) || (state == ST_HOLD);

   // R2: the soft-start request is a single-cycle pulse
   p_ss_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ss_req |=> !ss_req);

   // R8: the released supply is only left through the stop threshold
   p_drain_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DRAIN && !below_stop) |=> (state == ST_DRAIN));

   // R9: an active thermal latch pins the hold
   p_therm_pins_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && therm_hold) |=> (state == ST_HOLD));

   // R7: the hold is entered only from switching
   p_hold_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == ST_HOLD) |-> $past(state == ST_RUN));

endmodule

// File: rtl/autorestart_seq.sv
module autorestart_seq #(
   parameter int unsigned OVL_CYCLES  = 4_000_000,
   parameter int unsigned HOLD_CYCLES = 65_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vcc_above_start,
   input  logic vcc_below_stop,
   input  logic comp_over_ovl,
   input  logic vcc_over_ovp,
   input  logic fb_below_open,
   input  logic temp_hot,
   input  logic temp_cool,
   input  logic ss_active,
   output logic sw_en,
   output logic hvreg_en,
   output logic ss_req
);
   logic running;
   logic fault_now;
   logic therm_hold;

   arseq_fault_eval #(.OVL_CYCLES(OVL_CYCLES)) u_fault (
      .clk           (clk),
      .rst_n         (rst_n),
      .running       (running),
      .comp_over_ovl (comp_over_ovl),
      .vcc_over_ovp  (vcc_over_ovp),
      .fb_below_open (fb_below_open),
      .ss_active     (ss_active),
      .temp_hot      (temp_hot),
      .temp_cool     (temp_cool),
      .fault_now     (fault_now),
      .therm_hold    (therm_hold)
   );

   arseq_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .above_start (vcc_above_start),
      .below_stop  (vcc_below_stop),
      .fault_now   (fault_now),
      .therm_hold  (therm_hold),
      .running     (running),
      .sw_en       (sw_en),
      .hvreg_en    (hvreg_en),
      .ss_req      (ss_req)
   );

   // R10: switching only with the supply regulated, soft-start only while switching
   p_sw_needs_reg_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sw_en |-> hvreg_en);
   p_ss_in_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ss_req |-> sw_en);

   // R3: lockout while switching returns to charging
   p_uvlo_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en && vcc_below_stop) |=> (!sw_en && hvreg_en));

   // R5: over-voltage stops switching on the next cycle
   p_ovp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en && vcc_over_ovp) |=> !sw_en);

   // R6: unmasked open loop stops switching on the next cycle
   p_fb_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en && fb_below_open && !ss_active) |=> !sw_en);

endmodule

// File: tb/tb_autorestart_seq.sv
module tb_autorestart_seq;
   localparam int unsigned OVL  = 8;
   localparam int unsigned HOLD = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vcc_above_start = 0, vcc_below_stop = 0, comp_over_ovl = 0;
   logic vcc_over_ovp = 0, fb_below_open = 0, temp_hot = 0, temp_cool = 0;
   logic ss_active = 0;
   logic sw_en, hvreg_en, ss_req;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   autorestart_seq #(.OVL_CYCLES(OVL), .HOLD_CYCLES(HOLD)) dut (
      .clk(clk), .rst_n(rst_n),
      .vcc_above_start(vcc_above_start), .vcc_below_stop(vcc_below_stop),
      .comp_over_ovl(comp_over_ovl), .vcc_over_ovp(vcc_over_ovp),
      .fb_below_open(fb_below_open), .temp_hot(temp_hot), .temp_cool(temp_cool),
      .ss_active(ss_active),
      .sw_en(sw_en), .hvreg_en(hvreg_en), .ss_req(ss_req)
   );

   task automatic chk(string req, string what, logic act, logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // charging -> switching, checks the soft-start pulse (R2)
   task automatic go_run();
      vcc_above_start = 1;
      step();
      chk("R2", "sw_en on start", sw_en, 1'b1);
      chk("R2", "ss_req first cycle", ss_req, 1'b1);
      vcc_above_start = 0;
      step();
      chk("R2", "ss_req second cycle", ss_req, 1'b0);
      chk("R10", "sw_en keeps regulator", hvreg_en, 1'b1);
   endtask

   // called at the negedge right after the fault edge
   task automatic hold_and_drain(string req);
      chk(req, "sw_en after fault", sw_en, 1'b0);
      chk("R7", "hvreg_en at hold start", hvreg_en, 1'b1);
      for (int i = 1; i < HOLD; i++) begin
         step();
         chk("R7", "hvreg_en during hold", hvreg_en, 1'b1);
         chk("R7", "sw_en during hold", sw_en, 1'b0);
      end
      step();
      chk("R7", "hvreg_en after hold", hvreg_en, 1'b0);
   endtask

   task automatic drain_to_charge();
      vcc_above_start = 1;
      step();
      chk("R8", "start ignored while draining sw", sw_en, 1'b0);
      chk("R8", "start ignored while draining reg", hvreg_en, 1'b0);
      vcc_above_start = 0;
      vcc_below_stop = 1;
      step();
      chk("R8", "charging after stop level", hvreg_en, 1'b1);
      chk("R8", "no switching after stop level", sw_en, 1'b0);
      vcc_below_stop = 0;
   endtask

   initial begin
      // R1: reset state
      step();
      chk("R1", "sw_en in reset", sw_en, 1'b0);
      chk("R1", "hvreg_en in reset", hvreg_en, 1'b0);
      chk("R1", "ss_req in reset", ss_req, 1'b0);
      rst_n = 1;
      step();
      chk("R1", "charging after reset", hvreg_en, 1'b1);
      chk("R1", "no switching after reset", sw_en, 1'b0);
      step();
      chk("R2", "stays charging without start", sw_en, 1'b0);
      go_run();

      // R4: overload runs shorter than the window never trip
      for (int len = 1; len < OVL; len++) begin
         comp_over_ovl = 1;
         for (int k = 0; k < len; k++) begin
            step();
            chk("R4", "short overload run", sw_en, 1'b1);
         end
         comp_over_ovl = 0;
         step();
         chk("R4", "after short overload run", sw_en, 1'b1);
      end
      // R4: full window trips on its last edge
      comp_over_ovl = 1;
      for (int k = 1; k < OVL; k++) begin
         step();
         chk("R4", "overload window edge", sw_en, 1'b1);
      end
      step();
      comp_over_ovl = 0;
      hold_and_drain("R4");
      drain_to_charge();
      go_run();

      // R5: over-voltage
      vcc_over_ovp = 1;
      step();
      vcc_over_ovp = 0;
      hold_and_drain("R5");
      drain_to_charge();
      go_run();

      // R6: open loop masked by soft-start, then effective
      ss_active = 1;
      fb_below_open = 1;
      for (int k = 0; k < 4; k++) begin
         step();
         chk("R6", "open loop masked", sw_en, 1'b1);
      end
      ss_active = 0;
      step();
      fb_below_open = 0;
      hold_and_drain("R6");
      drain_to_charge();
      go_run();

      // R3: lockout while switching
      vcc_below_stop = 1;
      comp_over_ovl = 1;
      step();
      chk("R3", "sw_en after lockout", sw_en, 1'b0);
      chk("R3", "charging after lockout", hvreg_en, 1'b1);
      vcc_below_stop = 0;
      comp_over_ovl = 0;
      go_run();

      // R9: thermal shutdown extends the hold
      temp_hot = 1;
      step();
      temp_hot = 0;
      chk("R9", "sw_en after over-temperature", sw_en, 1'b0);
      for (int i = 1; i < HOLD + 6; i++) begin
         step();
         chk("R9", "hold kept while hot", hvreg_en, 1'b1);
      end
      temp_cool = 1;
      step();
      chk("R9", "first edge after recovery", hvreg_en, 1'b1);
      temp_cool = 0;
      step();
      chk("R9", "released after recovery", hvreg_en, 1'b0);
      drain_to_charge();
      go_run();
      chk("R10", "ss_req low while running", ss_req, 1'b0);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule